// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block is the front end that turns processor accesses into enhanced-parallel-port address and data cycles on the host side of a parallel port. It holds the port's data and control registers. It keeps a sticky error flag that is merged into bit 0 of the status value. An address or data access at the two transfer offsets runs only when the stored control value matches the pattern for its direction. Such an access becomes a sequence of byte handshakes toward the peripheral side. The processor waits on `cpu_ready` until the last byte is answered or the sequence is abandoned.

The data transfer offset also takes 2-byte and 4-byte accesses. These are sent least significant byte first, and reads are assembled in the same order. If the peripheral flags an error, or stays silent for `TMO_CYCLES` clocks, the access ends early and the flag is set. Writes to the data and control registers that would not change the stored value are suppressed. A control write that flips the direction bit announces the new direction one cycle before the control update.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset the error flag is clear, control reads 0xCC, the data register reads 0xFF and `per_req` is low.
- R2: A write at offset 3 or 4 starts a transfer only when (control AND 0x2F) == 0x04. Otherwise it completes with `cpu_ready` in the same cycle, and `per_req` stays low.
- R3: A read at offset 3 or 4 starts a transfer only when (control AND 0x2F) == 0x24. Otherwise no transfer runs, and the read returns all ones at its width (0xFF, 0xFFFF or 0xFFFFFFFF) with the upper bits zero.
- R4: While a byte is in flight, `per_req` stays high and `per_wdata` stays stable. `per_is_addr` is 1 for offset 3 and 0 for offset 4, and `per_write` gives the direction. `cpu_ready` rises one cycle after the clock that took the last response and is never high together with `per_req`.
- R5: At offset 4, `cpu_size` 0, 1 and 2 (3 acts as 2) move 1, 2 and 4 bytes. Byte i is bits [8i+7:8i] and goes out in order i = 0, 1, ... A read returns the received bytes in the same positions. All other offsets use a single byte.
- R6: An error response sets the sticky flag and ends the access at once. No further bytes are issued, and bytes of a read that were not received read as 0xFF.
- R7: A byte that gets no response within `TMO_CYCLES` clocks of `per_req` is handled as an error response.
- R8: A status read (offset 1) returns {per_status[7:1], flag}. A status write with bit 0 = 1 clears the flag, and a status write with bit 0 = 0 leaves it unchanged.
- R9: A write at offset 0 whose byte differs from the stored data stores it and pulses `data_upd` with `data_val`. A write of the same byte produces no pulse. A read at offset 0 returns the stored byte.
- R10: A control write (offset 2) stores the value ORed with 0xC0 and pulses `ctrl_upd` with that value in `ctrl_val`. If the ORed value equals the stored control, there is no pulse and nothing changes.
- R11: A control write that changes bit 5 (direction) pulses `dir_chg` with the new bit on `dir_val` in its first cycle. `ctrl_upd` and `cpu_ready` follow in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held with its fields until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register offset |
| cpu_size | input | 2 | Access width at offset 4: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes at this clock edge |
| per_status | input | 8 | Status lines from the peripheral side |
| per_req | output | 1 | Byte transfer in flight |
| per_is_addr | output | 1 | 1 = address cycle, 0 = data cycle |
| per_write | output | 1 | 1 = host to peripheral |
| per_wdata | output | 8 | Byte being written |
| per_rdata | input | 8 | Byte returned with `per_done` on reads |
| per_done | input | 1 | Byte completed |
| per_err | input | 1 | Byte failed |
| data_upd | output | 1 | Data register changed |
| data_val | output | 8 | New data register value |
| ctrl_upd | output | 1 | Control register changed |
| ctrl_val | output | 8 | New control value |
| dir_chg | output | 1 | Direction is about to change |
| dir_val | output | 1 | New direction, 1 = read |

## Verification
The hardest cases to reach are failures in the middle of a wide transfer and the silent peripheral. In these, the error flag, the truncated byte sequence and the partially filled read word must all agree. The bench drives the peripheral side with a scripted responder that can fail on any chosen byte index, add a fixed wait per byte, or never answer. A behavioural model predicts the completion cycle, the bytes seen on the handshake and the returned word for each access. Before that, the control register is walked through the write pattern, the read pattern and gated-off values, so both directions are exercised.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;

    localparam int BUS_W  = 32;
    localparam int BYTE_W = 8;
    localparam int NBYTES = BUS_W / BYTE_W;
    localparam int IDX_W  = $clog2(NBYTES) + 1;

    localparam logic [7:0] CTL_DIR       = 8'h20;
    localparam logic [7:0] CTL_GATE_MASK = 8'h2F;
    localparam logic [7:0] CTL_GATE_WR   = 8'h04;
    localparam logic [7:0] CTL_GATE_RD   = 8'h24;
    localparam logic [7:0] CTL_FIXED     = 8'hC0;
    localparam logic [7:0] CTL_RESET     = 8'hCC;
    localparam logic [7:0] DAT_RESET     = 8'hFF;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_STAT  = 3'd1;
    localparam logic [2:0] OFS_CTRL  = 3'd2;
    localparam logic [2:0] OFS_EADDR = 3'd3;
    localparam logic [2:0] OFS_EDATA = 3'd4;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_DIR,
        ACC_XFER
    } acc_state_t;

    typedef struct packed {
        logic             is_addr;
        logic             write;
        logic [IDX_W-1:0] nbytes;
        logic [BUS_W-1:0] wdata;
    } xfer_cmd_t;

    function automatic logic [IDX_W-1:0] width_bytes(input logic [1:0] size, input logic wide_ok);
        if (!wide_ok)
            return IDX_W'(1);
        case (size)
            2'd0:    return IDX_W'(1);
            2'd1:    return IDX_W'(2);
            default: return IDX_W'(NBYTES);
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] width_mask(input logic [IDX_W-1:0] nb);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int b = 0; b < NBYTES; b++)
            if (b < int'(nb))
                m[b*BYTE_W +: BYTE_W] = '1;
        return m;
    endfunction

endpackage

// File: rtl/epp_gate_check.sv
module epp_gate_check
    import epp_gate_pkg::*;
(
    input  logic [7:0] ctrl,
    input  logic       is_write,
    output logic       ok
);
    logic [7:0] want;

    always_comb begin
        want = is_write ? CTL_GATE_WR : CTL_GATE_RD;
        ok   = ((ctrl & CTL_GATE_MASK) == want);
    end
endmodule

// File: rtl/epp_reg_file.sv
module epp_reg_file
    import epp_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] wr_val,
    input  logic       data_we,
    input  logic       ctrl_we,
    input  logic       flag_clr,
    input  logic       flag_set,
    output logic [7:0] data_q,
    output logic [7:0] ctrl_q,
    output logic       flag_q,
    output logic [7:0] ctrl_next,
    output logic       data_same,
    output logic       ctrl_same,
    output logic       dir_flip
);
    always_comb begin
        ctrl_next = wr_val | CTL_FIXED;
        data_same = (wr_val == data_q);
        ctrl_same = (ctrl_next == ctrl_q);
        dir_flip  = |((ctrl_next ^ ctrl_q) & CTL_DIR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= DAT_RESET;
            ctrl_q <= CTL_RESET;
            flag_q <= 1'b0;
        end else begin
            if (data_we)
                data_q <= wr_val;
            if (ctrl_we)
                ctrl_q <= ctrl_next;
            if (flag_set)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        flag_set |=> flag_q);

    p_ctrl_high_bits_r10: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (ctrl_q[7:6] == 2'b11));
endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq
    import epp_gate_pkg::*;
#(
    parameter int TMO_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  xfer_cmd_t        cmd_in,
    output logic             per_req,
    output logic             per_is_addr,
    output logic             per_write,
    output logic [7:0]       per_wdata,
    input  logic [7:0]       per_rdata,
    input  logic             per_done,
    input  logic             per_err,
    output logic             err_evt,
    output logic             fin,
    output logic [BUS_W-1:0] rd_word
);
    localparam int CNT_W = $clog2(TMO_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

    logic             active_q;
    xfer_cmd_t        cmd_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [BUS_W-1:0] buf_q;
    logic             fin_q;
    logic             tmo_hit;
    logic             ok_evt;
    logic             last_byte;

    always_comb begin
        tmo_hit   = active_q && !per_done && !per_err && (cnt_q == CNT_LAST);
        err_evt   = active_q && (per_err || tmo_hit);
        ok_evt    = active_q && per_done && !per_err;
        last_byte = (idx_q == cmd_q.nbytes - IDX_W'(1));
        per_wdata = '0;
        for (int b = 0; b < NBYTES; b++)
            if (int'(idx_q) == b)
                per_wdata = cmd_q.wdata[b*BYTE_W +: BYTE_W];
    end

    assign per_req     = active_q;
    assign per_is_addr = cmd_q.is_addr;
    assign per_write   = cmd_q.write;
    assign fin         = fin_q;
    assign rd_word     = buf_q & width_mask(cmd_q.nbytes);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cmd_q    <= '0;
            idx_q    <= '0;
            cnt_q    <= '0;
            buf_q    <= '1;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                cmd_q    <= cmd_in;
                idx_q    <= '0;
                cnt_q    <= '0;
                buf_q    <= '1;
            end else if (err_evt) begin
                active_q <= 1'b0;
                fin_q    <= 1'b1;
            end else if (ok_evt) begin
                if (!cmd_q.write) begin
                    for (int b = 0; b < NBYTES; b++)
                        if (int'(idx_q) == b)
                            buf_q[b*BYTE_W +: BYTE_W] <= per_rdata;
                end
                if (last_byte) begin
                    active_q <= 1'b0;
                    fin_q    <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                    cnt_q <= '0;
                end
            end else if (active_q) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    p_tmo_window_r7: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (cnt_q <= CNT_LAST));

    p_byte_held_r4: assert property (@(posedge clk) disable iff (rst)
        (per_req && !per_done && !per_err && !tmo_hit) |=> (per_req && $stable(per_wdata)));

    p_no_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> !active_q);
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
    import epp_gate_pkg::*;
#(
    parameter int TMO_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [2:0]  cpu_addr,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_ready,
    input  logic [7:0]  per_status,
    output logic        per_req,
    output logic        per_is_addr,
    output logic        per_write,
    output logic [7:0]  per_wdata,
    input  logic [7:0]  per_rdata,
    input  logic        per_done,
    input  logic        per_err,
    output logic        data_upd,
    output logic [7:0]  data_val,
    output logic        ctrl_upd,
    output logic [7:0]  ctrl_val,
    output logic        dir_chg,
    output logic        dir_val
);
    acc_state_t       state_q, state_d;
    logic [7:0]       data_q, ctrl_q, ctrl_next;
    logic             flag_q, data_same, ctrl_same, dir_flip;
    logic             data_we, ctrl_we, flag_clr, err_evt;
    logic             gate_ok, is_epp, seq_start, seq_fin;
    logic [IDX_W-1:0] nb;
    logic [BUS_W-1:0] seq_word;
    xfer_cmd_t        cmd;

    epp_gate_check u_gate (
        .ctrl     (ctrl_q),
        .is_write (cpu_we),
        .ok       (gate_ok)
    );

    epp_reg_file u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_val    (cpu_wdata[7:0]),
        .data_we   (data_we),
        .ctrl_we   (ctrl_we),
        .flag_clr  (flag_clr),
        .flag_set  (err_evt),
        .data_q    (data_q),
        .ctrl_q    (ctrl_q),
        .flag_q    (flag_q),
        .ctrl_next (ctrl_next),
        .data_same (data_same),
        .ctrl_same (ctrl_same),
        .dir_flip  (dir_flip)
    );

    epp_byte_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (seq_start),
        .cmd_in      (cmd),
        .per_req     (per_req),
        .per_is_addr (per_is_addr),
        .per_write   (per_write),
        .per_wdata   (per_wdata),
        .per_rdata   (per_rdata),
        .per_done    (per_done),
        .per_err     (per_err),
        .err_evt     (err_evt),
        .fin         (seq_fin),
        .rd_word     (seq_word)
    );

    always_comb begin
        is_epp      = (cpu_addr == OFS_EADDR) || (cpu_addr == OFS_EDATA);
        nb          = width_bytes(cpu_size, cpu_addr == OFS_EDATA);
        cmd.is_addr = (cpu_addr == OFS_EADDR);
        cmd.write   = cpu_we;
        cmd.nbytes  = nb;
        cmd.wdata   = cpu_wdata;
        ctrl_val    = ctrl_next;
        dir_val     = ctrl_next[5];
        data_val    = cpu_wdata[7:0];
    end

    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_rdata = '0;
        data_we   = 1'b0;
        ctrl_we   = 1'b0;
        flag_clr  = 1'b0;
        seq_start = 1'b0;
        data_upd  = 1'b0;
        ctrl_upd  = 1'b0;
        dir_chg   = 1'b0;
        case (state_q)
            ACC_IDLE: begin
                if (cpu_req) begin
                    if (is_epp) begin
                        if (gate_ok) begin
                            seq_start = 1'b1;
                            state_d   = ACC_XFER;
                        end else begin
                            cpu_ready = 1'b1;
                            cpu_rdata = cpu_we ? '0 : width_mask(nb);
                        end
                    end else if (cpu_we) begin
                        case (cpu_addr)
                            OFS_DATA: begin
                                cpu_ready = 1'b1;
                                data_we   = !data_same;
                                data_upd  = !data_same;
                            end
                            OFS_STAT: begin
                                cpu_ready = 1'b1;
                                flag_clr  = cpu_wdata[0];
                            end
                            OFS_CTRL: begin
                                if (ctrl_same) begin
                                    cpu_ready = 1'b1;
                                end else if (dir_flip) begin
                                    dir_chg = 1'b1;
                                    state_d = ACC_DIR;
                                end else begin
                                    ctrl_we   = 1'b1;
                                    ctrl_upd  = 1'b1;
                                    cpu_ready = 1'b1;
                                end
                            end
                            default: cpu_ready = 1'b1;
                        endcase
                    end else begin
                        cpu_ready = 1'b1;
                        case (cpu_addr)
                            OFS_DATA: cpu_rdata = {24'd0, data_q};
                            OFS_STAT: cpu_rdata = {24'd0, per_status[7:1], flag_q};
                            OFS_CTRL: cpu_rdata = {24'd0, ctrl_q};
                            default:  cpu_rdata = 32'h0000_00FF;
                        endcase
                    end
                end
            end
            ACC_DIR: begin
                ctrl_we   = 1'b1;
                ctrl_upd  = 1'b1;
                cpu_ready = 1'b1;
                state_d   = ACC_IDLE;
            end
            ACC_XFER: begin
                if (seq_fin) begin
                    cpu_ready = 1'b1;
                    cpu_rdata = per_write ? '0 : seq_word;
                    state_d   = ACC_IDLE;
                end
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ACC_IDLE;
        else
            state_q <= state_d;
    end

    p_wr_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (per_req && per_write) |-> ((ctrl_q & CTL_GATE_MASK) == CTL_GATE_WR));

    p_rd_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (per_req && !per_write) |-> ((ctrl_q & CTL_GATE_MASK) == CTL_GATE_RD));

    p_ready_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(per_req && cpu_ready));

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(cpu_req && cpu_we && (cpu_addr == OFS_STAT) && cpu_wdata[0]));

    p_ctrl_redundant_r10: assert property (@(posedge clk) disable iff (rst)
        ctrl_upd |-> (ctrl_val != ctrl_q));

    p_dir_first_r11: assert property (@(posedge clk) disable iff (rst)
        dir_chg |=> (ctrl_upd && cpu_ready));
endmodule

// File: tb/epp_cycle_gate_bench.sv
module epp_cycle_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic [7:0]  per_status = 8'hA5;
    logic        per_req, per_is_addr, per_write;
    logic [7:0]  per_wdata;
    logic [7:0]  per_rdata = '0;
    logic        per_done = 1'b0, per_err = 1'b0;
    logic        data_upd, ctrl_upd, dir_chg, dir_val;
    logic [7:0]  data_val, ctrl_val;

    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    epp_cycle_gate #(.TMO_CYCLES(TMO)) u_epp_cycle_gate (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .per_status(per_status), .per_req(per_req), .per_is_addr(per_is_addr),
        .per_write(per_write), .per_wdata(per_wdata), .per_rdata(per_rdata),
        .per_done(per_done), .per_err(per_err), .data_upd(data_upd), .data_val(data_val),
        .ctrl_upd(ctrl_upd), .ctrl_val(ctrl_val), .dir_chg(dir_chg), .dir_val(dir_val)
    );

    // scripted peripheral responder
    int          rsp_delay = 0, rsp_err_idx = -1;
    bit          rsp_silent = 1'b0;
    logic [31:0] rsp_word = '0;
    int          r_w = 0, r_idx = 0;
    logic [7:0]  q_data[$];
    bit          q_addr[$];
    bit          q_wr[$];

    always @(negedge clk) begin
        per_done <= 1'b0;
        per_err  <= 1'b0;
        if (!per_req) begin
            r_w = 0;
            r_idx = 0;
        end else if (!rsp_silent) begin
            if (r_w == rsp_delay) begin
                if (r_idx == rsp_err_idx) per_err <= 1'b1;
                else                      per_done <= 1'b1;
                per_rdata <= 8'(rsp_word >> (8*r_idx));
                q_data.push_back(per_wdata);
                q_addr.push_back(per_is_addr);
                q_wr.push_back(per_write);
                r_idx++;
                r_w = 0;
            end else begin
                r_w++;
            end
        end
    end

    // reference state
    logic [7:0] m_ctrl = 8'hCC, m_data = 8'hFF;
    bit         m_flag = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int          a_cyc, a_dcyc, a_ccyc, a_ucyc;
    bit          a_dv;
    logic [7:0]  a_cv, a_uv;
    logic [31:0] a_rd;

    task automatic acc(input bit we, input logic [2:0] ad, input logic [1:0] sz, input logic [31:0] wd);
        a_cyc = 0; a_dcyc = -1; a_ccyc = -1; a_ucyc = -1;
        a_dv = 0; a_cv = 0; a_uv = 0; a_rd = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = ad; cpu_size = sz; cpu_wdata = wd;
        #1;
        while (1) begin
            if (dir_chg)  begin a_dcyc = a_cyc; a_dv = dir_val; end
            if (ctrl_upd) begin a_ccyc = a_cyc; a_cv = ctrl_val; end
            if (data_upd) begin a_ucyc = a_cyc; a_uv = data_val; end
            if (per_req && cpu_ready) chk("R4 ready with per_req", 1, 0);
            if (cpu_ready) begin a_rd = cpu_rdata; break; end
            a_cyc++;
            if (a_cyc > 2000) begin chk("access hung", 1, 0); break; end
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    // EPP access against the model
    task automatic epp(input string tag, input bit we, input logic [2:0] ad, input logic [1:0] sz,
                       input logic [31:0] wd, input int dly, input int erri, input bit silent,
                       input logic [31:0] word);
        int nb, proc, base, good;
        bit gated, fail;
        logic [31:0] mask, exp_rd;
        nb = (ad == 3'd4) ? ((sz == 0) ? 1 : (sz == 1) ? 2 : 4) : 1;
        mask = (nb == 1) ? 32'hFF : (nb == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
        gated = we ? ((m_ctrl & 8'h2F) == 8'h04) : ((m_ctrl & 8'h2F) == 8'h24);
        rsp_delay = dly; rsp_err_idx = erri; rsp_silent = silent; rsp_word = word;
        base = q_data.size();
        acc(we, ad, sz, wd);
        if (!gated) begin
            chk({tag, " gated cycles"}, a_cyc, 0);
            chk({tag, " gated rdata"}, a_rd, we ? 32'h0 : mask);
            chk({tag, " gated no bytes"}, q_data.size() - base, 0);
        end else begin
            fail = silent || (erri >= 0 && erri < nb);
            proc = silent ? 0 : ((erri >= 0 && erri < nb) ? erri + 1 : nb);
            good = fail ? (silent ? 0 : proc - 1) : proc;
            exp_rd = 32'hFFFF_FFFF;
            for (int i = 0; i < good; i++) exp_rd[8*i +: 8] = word[8*i +: 8];
            chk({tag, " cycles"}, a_cyc, silent ? TMO + 1 : proc * (dly + 1) + 1);
            chk({tag, " rdata"}, a_rd, we ? 32'h0 : (exp_rd & mask));
            chk({tag, " byte count"}, q_data.size() - base, proc);
            for (int i = 0; i < proc && base + i < q_data.size(); i++) begin
                if (we) chk({tag, " byte value"}, q_data[base+i], wd[8*i +: 8]);
                chk({tag, " byte kind"}, {q_addr[base+i], q_wr[base+i]}, {ad == 3'd3, we});
            end
            if (fail) m_flag = 1'b1;
        end
        rsp_silent = 1'b0; rsp_err_idx = -1;
    endtask

    task automatic ctrl_wr(input string tag, input logic [7:0] v);
        logic [7:0] nv;
        bit flip;
        nv = v | 8'hC0;
        flip = ((nv ^ m_ctrl) & 8'h20) != 0;
        acc(1'b1, 3'd2, 2'd0, {24'd0, v});
        if (nv == m_ctrl) begin
            chk({tag, " R10 no ctrl_upd"}, a_ccyc, -1);
            chk({tag, " R11 no dir_chg"}, a_dcyc, -1);
            chk({tag, " R10 cycles"}, a_cyc, 0);
        end else if (flip) begin
            chk({tag, " R11 dir_chg cycle"}, a_dcyc, 0);
            chk({tag, " R11 dir_val"}, a_dv, nv[5]);
            chk({tag, " R11 ctrl_upd cycle"}, a_ccyc, 1);
            chk({tag, " R11 ready cycle"}, a_cyc, 1);
            chk({tag, " R10 ctrl_val"}, a_cv, nv);
        end else begin
            chk({tag, " R10 ctrl_upd cycle"}, a_ccyc, 0);
            chk({tag, " R10 ctrl_val"}, a_cv, nv);
            chk({tag, " R11 no dir_chg"}, a_dcyc, -1);
        end
        m_ctrl = nv;
        acc(1'b0, 3'd2, 2'd0, 0);
        chk({tag, " R10 ctrl readback"}, a_rd, {24'd0, m_ctrl});
    endtask

    task automatic stat_chk(input string tag);
        acc(1'b0, 3'd1, 2'd0, 0);
        chk({tag, " R8 status"}, a_rd, {24'd0, per_status[7:1], m_flag});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 per_req in reset", per_req, 0);
        rst = 1'b0;
        // R1 reset values
        acc(1'b0, 3'd2, 2'd0, 0); chk("R1 control reset", a_rd, 32'hCC);
        acc(1'b0, 3'd0, 2'd0, 0); chk("R1 data reset", a_rd, 32'hFF);
        stat_chk("R1 flag clear");
        chk("R1 per_req idle", per_req, 0);
        // gated off at reset control
        epp("R2 addr write blocked", 1, 3'd3, 2'd0, 32'h5A, 0, -1, 0, 0);
        epp("R3 data read blocked 4B", 0, 3'd4, 2'd2, 0, 0, -1, 0, 0);
        epp("R3 data read blocked 2B", 0, 3'd4, 2'd1, 0, 0, -1, 0, 0);
        epp("R3 addr read blocked", 0, 3'd3, 2'd2, 0, 0, -1, 0, 0);
        // write pattern
        ctrl_wr("R10 set write mode", 8'h04);
        ctrl_wr("R10 repeat", 8'h04);
        ctrl_wr("R10 repeat with high bits", 8'hC4);
        epp("R4 addr write", 1, 3'd3, 2'd2, 32'h1234_565A, 1, -1, 0, 0);
        epp("R5 data write 4B", 1, 3'd4, 2'd2, 32'h4433_2211, 0, -1, 0, 0);
        epp("R5 data write 2B", 1, 3'd4, 2'd1, 32'h0000_BEEF, 2, -1, 0, 0);
        epp("R5 data write size3", 1, 3'd4, 2'd3, 32'hCAFE_F00D, 0, -1, 0, 0);
        epp("R3 read in write mode", 0, 3'd4, 2'd0, 0, 0, -1, 0, 0);
        stat_chk("R8 still clear");
        epp("R6 error mid write", 1, 3'd4, 2'd2, 32'h8877_6655, 0, 1, 0, 0);
        stat_chk("R6 flag set");
        acc(1'b1, 3'd1, 2'd0, 32'hFE);
        stat_chk("R8 write bit0 zero keeps");
        acc(1'b1, 3'd1, 2'd0, 32'h01); m_flag = 1'b0;
        stat_chk("R8 clear");
        epp("R7 silent write", 1, 3'd3, 2'd0, 32'h77, 0, -1, 1, 0);
        stat_chk("R7 flag after timeout");
        acc(1'b1, 3'd1, 2'd0, 32'h01); m_flag = 1'b0;
        // read pattern
        ctrl_wr("R11 to read", 8'h24);
        epp("R2 write in read mode", 1, 3'd4, 2'd0, 32'h33, 0, -1, 0, 0);
        epp("R5 data read 4B", 0, 3'd4, 2'd2, 0, 2, -1, 0, 32'hDDCC_BBAA);
        epp("R5 data read 2B", 0, 3'd4, 2'd1, 0, 0, -1, 0, 32'h1357_9BDF);
        epp("R4 addr read", 0, 3'd3, 2'd2, 0, 1, -1, 0, 32'h0000_00E1);
        epp("R6 error mid read", 0, 3'd4, 2'd2, 0, 0, 2, 0, 32'h4433_2211);
        stat_chk("R6 flag after read error");
        acc(1'b1, 3'd1, 2'd0, 32'h01); m_flag = 1'b0;
        epp("R7 silent read", 0, 3'd4, 2'd0, 0, 0, -1, 1, 32'h55);
        stat_chk("R7 flag after read timeout");
        epp("R6 flag stays on success", 0, 3'd4, 2'd0, 0, 0, -1, 0, 32'h66);
        stat_chk("R6 sticky");
        per_status = 8'h3C;
        stat_chk("R8 status merge");
        // data register
        acc(1'b1, 3'd0, 2'd0, 32'h37);
        chk("R9 data_upd cycle", a_ucyc, 0);
        chk("R9 data_val", a_uv, 8'h37);
        m_data = 8'h37;
        acc(1'b1, 3'd0, 2'd0, 32'h37);
        chk("R9 redundant no pulse", a_ucyc, -1);
        acc(1'b0, 3'd0, 2'd0, 0);
        chk("R9 data readback", a_rd, {24'd0, m_data});
        // back to a gated-off value with direction flip
        ctrl_wr("R11 back to write dir", 8'h0C);
        epp("R2 blocked by select", 1, 3'd4, 2'd2, 32'h0102_0304, 0, -1, 0, 0);
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule